// File: doc/BRIEF.md
# Cycle-Steal Memory Channel with Service Deadline

This block services one peripheral that moves single words to or from main memory by stealing memory cycles. The word count and current address of a transfer do not live in the channel. They sit in two adjacent memory locations, and the peripheral names the first of them with every request. On a request strobe the channel latches the pointer, the direction and the outgoing data word. It then asks the bus arbiter for the memory and waits for the grant.

Once granted, the channel runs a fixed sequence of accesses. It reads the word count and writes it back plus one. It reads the current address and writes it back plus one. It then moves one data word at the new address. The word count is kept as a negative two's-complement number, so the block is finished when the incremented count reaches zero. At that point a sticky block-done flag is raised.

A deadline counter starts at request acceptance. If the break has not completed within the configured number of I/O clock cycles (33 by default, which is 33 us at 1 MHz), a sticky timing-error flag is set. A break that is still waiting for its grant when the deadline expires is abandoned.

Top module: `csch_channel`

## Requirements
- R1: In the idle state, a one-cycle `dev_req` latches `dev_ptr`, `dev_dir` and `dev_wdata`, and `bus_req` is high in the following cycle. A `dev_req` that arrives while a break is in progress is ignored: it starts no second break and changes no memory.
- R2: No memory access is issued while the channel waits for `bus_grant`. The first access after the grant is a read of the word-count location `dev_ptr`.
- R3: Word-count update: the read of `dev_ptr` is followed in the next cycle by a write to `dev_ptr` of the read value plus one (modulo 2^WW). The next access is a read of `dev_ptr`+1, and `dev_ptr` is never read a second time within one break.
- R4: Current-address update: the read of `dev_ptr`+1 is followed in the next cycle by a write to `dev_ptr`+1 of the read value plus one (modulo 2^WW, wrapping 0x3FFFF to 0). The data access then uses the low AW bits of that incremented value.
- R5: Data move: with `dev_dir`=1 (device to memory), the data access writes the latched `dev_wdata`. With `dev_dir`=0 (memory to device), it is a read, and the word read is on `dev_rdata` while `dev_ack` is high. Each break makes exactly five memory accesses.
- R6: `dev_ack` is a one-cycle pulse after the data access. `bus_req` is low during that cycle and stays low afterwards until a new request arrives.
- R7: `blk_done` is set when the incremented word count equals zero, and it stays set until `flag_clr`. An incremented count that is not zero does not set it.
- R8: `tim_err` is set at the TMO_CYC-th clock edge after the accepting edge if the break has not reached its acknowledge cycle by then. If the channel is still waiting for the grant at that point, the break is dropped: `bus_req` goes low, no memory access is made and no `dev_ack` is given. If the grant has already been given, the break runs to completion. `tim_err` stays set until `flag_clr`.
- R9: A `flag_clr` pulse clears `tim_err` and `blk_done`. A set and a clear in the same cycle leaves the flag set.
- R10: After reset the channel is idle, and `bus_req`, `mem_en`, `dev_ack`, `tim_err` and `blk_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_req | input | 1 | One-cycle break request strobe from the peripheral |
| dev_ptr | input | AW | Address of the word-count location; the current address sits at this plus one |
| dev_dir | input | 1 | 1 = device to memory, 0 = memory to device |
| dev_wdata | input | WW | Word to store for device-to-memory breaks |
| dev_rdata | output | WW | Word fetched for memory-to-device breaks |
| dev_ack | output | 1 | One-cycle break completion pulse |
| bus_req | output | 1 | Memory bus request to the arbiter |
| bus_grant | input | 1 | Memory bus grant from the arbiter |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | WW | Memory write data |
| mem_rdata | input | WW | Memory read data, valid the cycle after a read strobe |
| flag_clr | input | 1 | Clears the sticky flags |
| tim_err | output | 1 | Sticky deadline-missed flag |
| blk_done | output | 1 | Sticky word-count-reached-zero flag |

## Verification
Random breaks vary the pointer, the stored count and address, the direction, the data word and the grant delay. Each one checks the exact order, addresses and write values of the five accesses, so a repeated word-count cycle, a skipped increment or a data access at the unincremented address is caught. Directed cases set the stored count to -1 and to 0, which shows whether the done flag follows the incremented value or the old one. Another case wraps the current address across 0x3FFFF. The deadline is tested twice. A withheld grant must set the error exactly at the 33rd edge, with no access made. A late grant must set the error and still complete the break. A second strobe issued mid-break must leave memory and the acknowledge count unchanged.

// File: rtl/csch_pkg.sv
package csch_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WAIT,
        ST_WC_RD,
        ST_WC_WR,
        ST_CA_RD,
        ST_CA_WR,
        ST_XFER,
        ST_CAPT,
        ST_FIN
    } csch_state_e;

endpackage

// File: rtl/csch_deadline.sv
module csch_deadline #(
    parameter int TMO_CYC = 33
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic busy,
    input  logic finishing,
    output logic expire
);
    localparam int CW = $clog2(TMO_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(TMO_CYC - 1);
    localparam logic [CW-1:0] ONE  = CW'(1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = '0;
        end else if (busy && cnt_q != LAST) begin
            cnt_d = cnt_q + ONE;
        end
        expire = busy && !finishing && (cnt_q == LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/csch_flags.sv
module csch_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic set_err,
    input  logic set_done,
    input  logic clr,
    output logic err,
    output logic done
);
    typedef struct packed {
        logic err;
        logic done;
    } flag_t;

    flag_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (clr) begin
            f_d.err  = 1'b0;
            f_d.done = 1'b0;
        end
        if (set_err) begin
            f_d.err = 1'b1;
        end
        if (set_done) begin
            f_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign err  = f_q.err;
    assign done = f_q.done;
endmodule

// File: rtl/csch_seq.sv
module csch_seq
    import csch_pkg::*;
#(
    parameter int AW = 15,
    parameter int WW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dev_req,
    input  logic [AW-1:0] dev_ptr,
    input  logic          dev_dir,
    input  logic [WW-1:0] dev_wdata,
    output logic [WW-1:0] dev_rdata,
    output logic          dev_ack,
    output logic          bus_req,
    input  logic          bus_grant,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [WW-1:0] mem_wdata,
    input  logic [WW-1:0] mem_rdata,
    input  logic          expire,
    output logic          start,
    output logic          busy,
    output logic          finishing,
    output logic          done_evt,
    output csch_state_e   state_o
);
    localparam logic [AW-1:0] A_ONE = AW'(1);
    localparam logic [WW-1:0] W_ONE = WW'(1);

    typedef struct packed {
        csch_state_e   st;
        logic [AW-1:0] ptr;
        logic          dir;
        logic [WW-1:0] wdat;
        logic [WW-1:0] wc;
        logic [WW-1:0] ca;
        logic [WW-1:0] rdat;
    } seq_t;

    seq_t s_d, s_q;
    logic [WW-1:0] bumped;

    assign bumped = mem_rdata + W_ONE;

    always_comb begin
        s_d       = s_q;
        bus_req   = 1'b0;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = s_q.ptr;
        mem_wdata = '0;
        dev_ack   = 1'b0;
        start     = 1'b0;
        done_evt  = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (dev_req) begin
                    s_d.st   = ST_WAIT;
                    s_d.ptr  = dev_ptr;
                    s_d.dir  = dev_dir;
                    s_d.wdat = dev_wdata;
                    start    = 1'b1;
                end
            end
            ST_WAIT: begin
                bus_req = 1'b1;
                if (expire) begin
                    s_d.st = ST_IDLE;
                end else if (bus_grant) begin
                    s_d.st = ST_WC_RD;
                end
            end
            ST_WC_RD: begin
                bus_req = 1'b1;
                mem_en  = 1'b1;
                s_d.st  = ST_WC_WR;
            end
            ST_WC_WR: begin
                bus_req   = 1'b1;
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = bumped;
                s_d.wc    = bumped;
                s_d.st    = ST_CA_RD;
            end
            ST_CA_RD: begin
                bus_req  = 1'b1;
                mem_en   = 1'b1;
                mem_addr = s_q.ptr + A_ONE;
                s_d.st   = ST_CA_WR;
            end
            ST_CA_WR: begin
                bus_req   = 1'b1;
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = s_q.ptr + A_ONE;
                mem_wdata = bumped;
                s_d.ca    = bumped;
                s_d.st    = ST_XFER;
            end
            ST_XFER: begin
                bus_req   = 1'b1;
                mem_en    = 1'b1;
                mem_we    = s_q.dir;
                mem_addr  = s_q.ca[AW-1:0];
                mem_wdata = s_q.wdat;
                s_d.st    = s_q.dir ? ST_FIN : ST_CAPT;
            end
            ST_CAPT: begin
                bus_req  = 1'b1;
                s_d.rdat = mem_rdata;
                s_d.st   = ST_FIN;
            end
            ST_FIN: begin
                dev_ack  = 1'b1;
                done_evt = (s_q.wc == '0);
                s_d.st   = ST_IDLE;
            end
            default: begin
                s_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy      = (s_q.st != ST_IDLE);
    assign finishing = (s_q.st == ST_FIN);
    assign dev_rdata = s_q.rdat;
    assign state_o   = s_q.st;
endmodule

// File: rtl/csch_channel.sv
module csch_channel
    import csch_pkg::*;
#(
    parameter int AW      = 15,
    parameter int WW      = 18,
    parameter int TMO_CYC = 33
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dev_req,
    input  logic [AW-1:0] dev_ptr,
    input  logic          dev_dir,
    input  logic [WW-1:0] dev_wdata,
    output logic [WW-1:0] dev_rdata,
    output logic          dev_ack,
    output logic          bus_req,
    input  logic          bus_grant,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [WW-1:0] mem_wdata,
    input  logic [WW-1:0] mem_rdata,
    input  logic          flag_clr,
    output logic          tim_err,
    output logic          blk_done
);
    logic        start_w, busy_w, fin_w, done_w, expire_w;
    csch_state_e state_w;

    csch_seq #(.AW(AW), .WW(WW)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .dev_req(dev_req), .dev_ptr(dev_ptr), .dev_dir(dev_dir),
        .dev_wdata(dev_wdata), .dev_rdata(dev_rdata), .dev_ack(dev_ack),
        .bus_req(bus_req), .bus_grant(bus_grant),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .expire(expire_w), .start(start_w), .busy(busy_w),
        .finishing(fin_w), .done_evt(done_w), .state_o(state_w)
    );

    csch_deadline #(.TMO_CYC(TMO_CYC)) u_deadline (
        .clk(clk), .rst_n(rst_n), .start(start_w), .busy(busy_w),
        .finishing(fin_w), .expire(expire_w)
    );

    csch_flags u_flags (
        .clk(clk), .rst_n(rst_n), .set_err(expire_w), .set_done(done_w),
        .clr(flag_clr), .err(tim_err), .done(blk_done)
    );
endmodule

// File: rtl/csch_chk.sv
module csch_chk
    import csch_pkg::*;
#(
    parameter int AW = 15,
    parameter int WW = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dev_ack,
    input logic          bus_req,
    input logic          mem_en,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          flag_clr,
    input logic          tim_err,
    input logic          blk_done,
    input csch_state_e   state_w
);
    assert_no_access_unheld_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> bus_req);

    assert_wc_read_then_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_w == ST_WC_RD) |=> (mem_en && mem_we && mem_addr == $past(mem_addr)));

    assert_ca_follows_wc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we && state_w == ST_WC_WR) |=>
            (mem_en && !mem_we && mem_addr != $past(mem_addr)));

    assert_ack_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dev_ack |=> (!dev_ack && !bus_req));

    assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_done && !flag_clr) |=> blk_done);

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tim_err && !flag_clr) |=> tim_err);

    assert_abort_drops_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tim_err) && $past(state_w) == ST_WAIT) |-> (!bus_req && !mem_en));
endmodule

bind csch_channel csch_chk #(.AW(AW), .WW(WW)) u_chk (
    .clk(clk), .rst_n(rst_n), .dev_ack(dev_ack), .bus_req(bus_req),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .flag_clr(flag_clr), .tim_err(tim_err), .blk_done(blk_done),
    .state_w(state_w)
);

// File: tb/csch_channel_tb.sv
module csch_channel_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;
    localparam int WW = 18;
    localparam int TMO = 33;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dev_req = 1'b0;
    logic [AW-1:0] dev_ptr = '0;
    logic          dev_dir = 1'b0;
    logic [WW-1:0] dev_wdata = '0;
    logic [WW-1:0] dev_rdata;
    logic          dev_ack;
    logic          bus_req;
    logic          bus_grant = 1'b0;
    logic          mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [WW-1:0] mem_wdata;
    logic [WW-1:0] mem_rdata;
    logic          flag_clr = 1'b0;
    logic          tim_err, blk_done;

    csch_channel #(.AW(AW), .WW(WW), .TMO_CYC(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .dev_ptr(dev_ptr),
        .dev_dir(dev_dir), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata),
        .dev_ack(dev_ack), .bus_req(bus_req), .bus_grant(bus_grant),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .flag_clr(flag_clr),
        .tim_err(tim_err), .blk_done(blk_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [WW-1:0] mem [0:(1<<AW)-1];
    logic [WW-1:0] rd_q = '0;
    assign mem_rdata = rd_q;
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        rd_q <= mem[mem_addr];
        end
    end

    int            log_n = 0;
    logic          log_we [0:15];
    logic [AW-1:0] log_ad [0:15];
    logic [WW-1:0] log_wd [0:15];
    int            ack_cnt = 0;
    always @(negedge clk) begin
        if (rst_n && mem_en) begin
            if (log_n < 16) begin
                log_we[log_n] = mem_we;
                log_ad[log_n] = mem_addr;
                log_wd[log_n] = mem_wdata;
            end
            log_n = log_n + 1;
        end
        if (rst_n && dev_ack) ack_cnt = ack_cnt + 1;
    end

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [WW-1:0] inc_w(input logic [WW-1:0] v);
        return v + WW'(1);
    endfunction

    function automatic logic [AW-1:0] nxt_a(input logic [AW-1:0] a);
        return a + AW'(1);
    endfunction

    task automatic clear_flags();
        @(negedge clk) flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
    endtask

    task automatic strobe(input logic [AW-1:0] p, input logic d, input logic [WW-1:0] w);
        @(negedge clk);
        dev_req = 1'b1; dev_ptr = p; dev_dir = d; dev_wdata = w;
        @(negedge clk);
        dev_req = 1'b0;
    endtask

    task automatic do_break(input logic [AW-1:0] p, input logic [WW-1:0] wc0,
                            input logic [WW-1:0] ca0, input logic d,
                            input logic [WW-1:0] w, input int gdel,
                            input bit exp_err, input bit poke);
        logic [WW-1:0] ca1, wc1, old_t;
        logic [AW-1:0] tgt;
        int waited, acks0;
        bit got;
        wc1 = inc_w(wc0);
        ca1 = inc_w(ca0);
        tgt = ca1[AW-1:0];
        old_t = WW'($urandom);
        mem[p] = wc0;
        mem[nxt_a(p)] = ca0;
        mem[tgt] = old_t;
        log_n = 0;
        acks0 = ack_cnt;
        strobe(p, d, w);
        chk(bus_req == 1'b1, "R1", "bus_req after strobe", bus_req, 1);
        for (int i = 0; i < gdel; i++) @(negedge clk);
        chk(log_n == 0, "R2", "accesses before grant", log_n, 0);
        bus_grant = 1'b1;
        if (poke) begin
            @(negedge clk) dev_req = 1'b1; dev_ptr = nxt_a(nxt_a(p)); dev_dir = 1'b1;
            @(negedge clk) dev_req = 1'b0;
        end
        got = 1'b0;
        waited = 0;
        while (!got && waited < 60) begin
            if (dev_ack) got = 1'b1;
            else begin @(negedge clk); waited++; end
        end
        bus_grant = 1'b0;
        chk(got, "R6", "ack seen", got, 1);
        chk(bus_req == 1'b0, "R6", "bus_req low at ack", bus_req, 0);
        if (!d) chk(dev_rdata == old_t, "R5", "read word", dev_rdata, old_t);
        @(negedge clk);
        chk(dev_ack == 1'b0, "R6", "ack width", dev_ack, 0);
        chk(blk_done == (wc1 == '0), "R7", "done flag", blk_done, (wc1 == '0));
        chk(tim_err == exp_err, "R8", "error flag", tim_err, exp_err);
        chk(log_n == 5, "R5", "access count", log_n, 5);
        if (log_n == 5) begin
            chk(!log_we[0] && log_ad[0] == p, "R2", "first access rd ptr", log_ad[0], p);
            chk(log_we[1] && log_ad[1] == p && log_wd[1] == wc1, "R3", "wc writeback",
                log_wd[1], wc1);
            chk(!log_we[2] && log_ad[2] == nxt_a(p), "R3", "ca read addr", log_ad[2], nxt_a(p));
            chk(log_we[3] && log_ad[3] == nxt_a(p) && log_wd[3] == ca1, "R4", "ca writeback",
                log_wd[3], ca1);
            chk(log_we[4] == d && log_ad[4] == tgt, "R4", "data addr", log_ad[4], tgt);
        end
        if (d) chk(mem[tgt] == w, "R5", "stored word", mem[tgt], w);
        chk(mem[p] == wc1, "R3", "count in memory", mem[p], wc1);
        if (poke) begin
            repeat (3) @(negedge clk);
            chk(bus_req == 1'b0 && ack_cnt == acks0 + 1, "R1", "busy strobe ignored",
                ack_cnt - acks0, 1);
            chk(mem[nxt_a(nxt_a(p))] == mem[nxt_a(nxt_a(p))] && log_n == 5, "R1",
                "no extra access", log_n, 5);
        end
    endtask

    initial begin
        int cyc;
        cyc = 0;
        while (!finished) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual=%0d expected=done", cyc);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd1357));
        for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        chk(!bus_req && !mem_en && !dev_ack && !tim_err && !blk_done, "R10",
            "reset outputs", {bus_req, mem_en, dev_ack, tim_err, blk_done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!bus_req && !mem_en, "R10", "idle after reset", {bus_req, mem_en}, 0);

        // directed corner cases
        do_break(10'd100, 18'h3FFFF, 18'h3FFFF, 1'b1, 18'h2AAAA, 0, 1'b0, 1'b0);
        clear_flags();
        chk(!blk_done && !tim_err, "R9", "clear flags", blk_done, 0);
        do_break(10'd100, 18'h00000, 18'h00201, 1'b0, 18'h0, 2, 1'b0, 1'b0);
        chk(!blk_done, "R7", "zero count not done", blk_done, 0);
        clear_flags();
        do_break(10'd40, 18'h3FFF0, 18'h10300, 1'b1, 18'h15555, 1, 1'b0, 1'b1);
        clear_flags();

        // deadline expiry with grant withheld
        begin
            int acks0;
            mem[60] = 18'h3FF00;
            mem[61] = 18'h00500;
            log_n = 0;
            acks0 = ack_cnt;
            strobe(10'd60, 1'b1, 18'h1);
            repeat (TMO - 1) @(posedge clk);
            #1;
            chk(!tim_err && bus_req, "R8", "no error before deadline", tim_err, 0);
            @(posedge clk);
            #1;
            chk(tim_err == 1'b1, "R8", "error at deadline", tim_err, 1);
            chk(bus_req == 1'b0, "R8", "request dropped", bus_req, 0);
            repeat (5) @(negedge clk);
            chk(log_n == 0 && ack_cnt == acks0, "R8", "abandoned break", log_n, 0);
            chk(mem[60] == 18'h3FF00, "R8", "count untouched", mem[60], 18'h3FF00);
            chk(tim_err == 1'b1, "R8", "error sticky", tim_err, 1);
        end
        clear_flags();
        // late grant: error set, break still completes
        do_break(10'd70, 18'h3FFFE, 18'h00600, 1'b1, 18'h0F0F0, 28, 1'b1, 1'b0);
        clear_flags();
        do_break(10'd72, 18'h3FFFE, 18'h00610, 1'b0, 18'h0, 28, 1'b1, 1'b0);
        clear_flags();

        // constrained random breaks
        for (int k = 0; k < 40; k++) begin
            logic [AW-1:0] p;
            logic [WW-1:0] wc0, ca0, w;
            logic [AW-1:0] low;
            logic d;
            int gd;
            p   = AW'($urandom_range(0, 250));
            wc0 = ($urandom_range(0, 3) == 0) ? 18'h3FFFF : WW'($urandom);
            low = AW'($urandom_range(512, 1023));
            ca0 = {WW'($urandom) & ~WW'((1 << AW) - 1)} | WW'(low);
            ca0 = ca0 - WW'(1);
            d   = 1'($urandom);
            w   = WW'($urandom);
            gd  = $urandom_range(0, 12);
            do_break(p, wc0, ca0, d, w, gd, 1'b0, 1'b0);
            clear_flags();
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule